// File: doc/BRIEF.md
# Address-Decoding Interconnect with Per-Target Burst Splitting

This block joins several initiators to several memory-mapped targets through one shared path. An initiator raises a request that carries a global address, a write flag, a word count of one up to `MAX_WORDS`, and all of its write words packed into one bus. A fixed-priority arbiter picks one initiator. The chosen address is compared against each target's half-open window `[base, base + size)`. The matching target then sees the request with its own base subtracted from the address. A request that matches no window, or whose count is out of range, gets an error response and no target sees it.

Each target port is built either as a burst port or as a single-word port. A burst port gets the whole transfer as one transaction. A single-word port gets one one-word transaction per word, at addresses that advance by `DW/8` when byte addressing is selected (the default) or by 1 in word-address mode. In both cases the initiator gets back one response pulse with all of its read words. It cannot tell which kind of port served it. Timing follows a fixed forward latency, the target's own access time (the cycles from issue to `tgt_ack`), a fixed return latency on burst reads, and one cycle per word.

Top module: `mmap_fabric`

## Requirements
- R1: A request goes only to the lowest-numbered target whose window satisfies base <= address < base + size. At most one `tgt_valid` bit is ever high, and no other target is issued anything.
- R2: The address presented on `tgt_addr` for the first word is the global address minus the selected target's base.
- R3: If an address hits no window, the response is given in the cycle right after acceptance, with `rsp_err` = 1. No `tgt_valid` rises for that request. The output `err_seen` goes to 1 and stays at 1 until reset.
- R4: A count of 0, or a count above `MAX_WORDS`, is rejected in the same way as R3, even when the address is mapped.
- R5: On a burst port, a write is issued once, with `tgt_len` equal to the count and word j in bits [32j+31:32j] of `tgt_wdata`. The response comes FWD_LAT + N + 1 cycles after the accepting cycle, and no `tgt_ack` is waited for.
- R6: On a burst port, a read is issued once, and the target's `tgt_rdata` is captured on `tgt_ack`. The response comes FWD_LAT + D + RET_LAT + N + 1 cycles after acceptance, where D is the number of cycles from `tgt_valid` to `tgt_ack`. `rsp_rdata` carries the target's words unchanged.
- R7: On a single-word port, an N-word request becomes N issues, each with `tgt_len` = 1. Issue i uses address local + 4·i in the default byte mode, and for writes it carries word i in lane 0. Each issue after the first comes the cycle after the previous `tgt_ack`. Read word i is taken from lane 0 of the i-th acknowledge into lane i of `rsp_rdata`. The response comes FWD_LAT + N·(D + 1) cycles after acceptance.
- R8: When more than one initiator is requesting, only the lowest-numbered one sees `ini_ready`. No `ini_ready` is high from acceptance until one cycle after the response. A waiting initiator is granted in the cycle after the response.
- R9: A response is a single-cycle pulse on the `rsp_valid` bit of the granted initiator only. `rsp_err` is high only together with a `rsp_valid` pulse.
- R10: After reset, `tgt_valid`, `rsp_valid` and `err_seen` are all 0. `ini_ready` is 0 while no initiator is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ini_valid | input | N_INIT | Request present, one bit per initiator |
| ini_ready | output | N_INIT | Request taken this cycle |
| ini_write | input | N_INIT | 1 = write, 0 = read |
| ini_addr | input | N_INIT*AW | Global start address per initiator |
| ini_len | input | N_INIT*LW | Word count per initiator |
| ini_wdata | input | N_INIT*MAX_WORDS*DW | Packed write words, word j in lane j |
| rsp_valid | output | N_INIT | Completion pulse to the granted initiator |
| rsp_err | output | 1 | Completion is an error |
| rsp_rdata | output | MAX_WORDS*DW | Packed read words |
| err_seen | output | 1 | Sticky flag: an error response has been given since reset |
| tgt_valid | output | N_TGT | Transaction issue pulse, one bit per target |
| tgt_write | output | 1 | Direction of the issued transaction |
| tgt_addr | output | AW | Target-relative address |
| tgt_len | output | LW | Words in the issued transaction |
| tgt_wdata | output | MAX_WORDS*DW | Write words of the issued transaction |
| tgt_ack | input | N_TGT | Target finished its access |
| tgt_rdata | input | N_TGT*MAX_WORDS*DW | Read words per target, valid with `tgt_ack` |

## Verification
The bench probes the window edges in several places: the last word inside a window, the first address past its end, the gap between windows, and the end of the register window. A design that compares against an inclusive upper bound would route these to a target instead of returning an error. Zero and oversize counts check that a bad count is caught before anything is issued. A design that let them through would issue a transaction of length 0 or overrun the data lanes. On the single-word port the bench compares every beat's address, length and lane. A design with a wrong step, a stale lane, or beats issued before the acknowledge would show up as mismatches or as a shifted completion cycle. Two initiators that request together check that the lower index wins and that the other is held off through every beat. A design that re-arbitrated mid-transfer would let the second request slip in early.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD,
    ST_ISSUE,
    ST_WAIT,
    ST_COUNT,
    ST_RESP
  } fsm_t;

  // half-open window test, written so base + size never has to be formed
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

  // address of beat n of a split transfer
  function automatic logic [31:0] beat_addr(input logic [31:0] first,
                                            input logic [31:0] beat,
                                            input logic [31:0] step);
    return first + beat * step;
  endfunction

endpackage

// File: rtl/mmf_prio_arb.sv
module mmf_prio_arb #(
  parameter int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mmf_decode.sv
module mmf_decode #(
  parameter int N_TGT = 2,
  parameter int AW    = 16,
  parameter logic [N_TGT*AW-1:0] TGT_BASE = '0,
  parameter logic [N_TGT*AW-1:0] TGT_SIZE = '0,
  localparam int TW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit_any,
  output logic [TW-1:0] sel,
  output logic [AW-1:0] local_addr
);
  logic [N_TGT-1:0] hit;

  for (genvar k = 0; k < N_TGT; k++) begin : g_win
    assign hit[k] = mmf_pkg::in_window(32'(addr),
                                       32'(TGT_BASE[k*AW +: AW]),
                                       32'(TGT_SIZE[k*AW +: AW]));
  end

  // lowest index wins when windows overlap
  always_comb begin
    hit_any    = 1'b0;
    sel        = '0;
    local_addr = '0;
    for (int k = N_TGT - 1; k >= 0; k--) begin
      if (hit[k]) begin
        hit_any    = 1'b1;
        sel        = TW'(k);
        local_addr = addr - TGT_BASE[k*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/mmap_fabric.sv
module mmap_fabric #(
  parameter int N_INIT    = 2,
  parameter int N_TGT     = 2,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 4,
  parameter int FWD_LAT   = 2,   // must be at least 1
  parameter int RET_LAT   = 2,
  parameter bit BYTE_ADDR = 1'b1,
  parameter logic [N_TGT*AW-1:0] TGT_BASE   = {16'h2000, 16'h0000},
  parameter logic [N_TGT*AW-1:0] TGT_SIZE   = {16'h0040, 16'h1000},
  parameter logic [N_TGT-1:0]    TGT_SINGLE = 2'b10,
  localparam int LW   = $clog2(MAX_WORDS + 1),
  localparam int PW   = MAX_WORDS * DW,
  localparam int IW   = (N_INIT > 1) ? $clog2(N_INIT) : 1,
  localparam int TW   = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int CNTW = $clog2(FWD_LAT + RET_LAT + MAX_WORDS + 1) + 1,
  localparam int STEP = BYTE_ADDR ? DW / 8 : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_INIT-1:0]      ini_valid,
  output logic [N_INIT-1:0]      ini_ready,
  input  logic [N_INIT-1:0]      ini_write,
  input  logic [N_INIT*AW-1:0]   ini_addr,
  input  logic [N_INIT*LW-1:0]   ini_len,
  input  logic [N_INIT*PW-1:0]   ini_wdata,
  output logic [N_INIT-1:0]      rsp_valid,
  output logic                   rsp_err,
  output logic [PW-1:0]          rsp_rdata,
  output logic                   err_seen,
  output logic [N_TGT-1:0]       tgt_valid,
  output logic                   tgt_write,
  output logic [AW-1:0]          tgt_addr,
  output logic [LW-1:0]          tgt_len,
  output logic [PW-1:0]          tgt_wdata,
  input  logic [N_TGT-1:0]       tgt_ack,
  input  logic [N_TGT*PW-1:0]    tgt_rdata
);
  import mmf_pkg::*;

  fsm_t            state;
  logic [CNTW-1:0] cnt;
  logic [IW-1:0]   gnt_q;
  logic [TW-1:0]   tgt_q;
  logic            single_q;
  logic            write_q;
  logic            err_q;
  logic [LW-1:0]   len_q;
  logic [LW-1:0]   beat_q;
  logic [AW-1:0]   laddr_q;
  logic [PW-1:0]   wbuf;
  logic [PW-1:0]   rbuf;

  // arbitration
  logic          arb_any;
  logic [IW-1:0] arb_idx;

  mmf_prio_arb #(.N(N_INIT)) u_arb (
    .req (ini_valid),
    .any (arb_any),
    .idx (arb_idx)
  );

  // fields of the winning request
  logic [AW-1:0] sel_addr;
  logic [LW-1:0] sel_len;
  logic [PW-1:0] sel_wdata;
  logic          sel_write;

  assign sel_addr  = ini_addr[arb_idx*AW +: AW];
  assign sel_len   = ini_len[arb_idx*LW +: LW];
  assign sel_wdata = ini_wdata[arb_idx*PW +: PW];
  assign sel_write = ini_write[arb_idx];

  // address decode
  logic          dec_hit;
  logic [TW-1:0] dec_sel;
  logic [AW-1:0] dec_local;

  mmf_decode #(
    .N_TGT    (N_TGT),
    .AW       (AW),
    .TGT_BASE (TGT_BASE),
    .TGT_SIZE (TGT_SIZE)
  ) u_dec (
    .addr       (sel_addr),
    .hit_any    (dec_hit),
    .sel        (dec_sel),
    .local_addr (dec_local)
  );

  // named events used by the fsm and by the checker
  logic len_ok, req_ok, accept, issue, ack_sel, last_beat, busy;
  logic [PW-1:0] sel_rdata;

  assign len_ok    = (sel_len != '0) && (32'(sel_len) <= MAX_WORDS);
  assign req_ok    = dec_hit && len_ok;
  assign accept    = (state == ST_IDLE) && arb_any;
  assign issue     = ((state == ST_FWD) && (cnt == '0)) || (state == ST_ISSUE);
  assign sel_rdata = tgt_rdata[tgt_q*PW +: PW];
  assign ack_sel   = (state == ST_WAIT) && tgt_ack[tgt_q];
  assign last_beat = (beat_q == LW'(len_q - 1'b1));
  assign busy      = (state != ST_IDLE);

  // initiator side
  for (genvar i = 0; i < N_INIT; i++) begin : g_ini
    assign ini_ready[i] = accept && (arb_idx == IW'(i));
    assign rsp_valid[i] = (state == ST_RESP) && (gnt_q == IW'(i));
  end
  assign rsp_err   = (state == ST_RESP) && err_q;
  assign rsp_rdata = rbuf;

  // target side
  for (genvar k = 0; k < N_TGT; k++) begin : g_tgt
    assign tgt_valid[k] = issue && (tgt_q == TW'(k));
  end
  assign tgt_write = write_q;
  assign tgt_addr  = AW'(beat_addr(32'(laddr_q), 32'(beat_q), 32'(STEP)));
  assign tgt_len   = single_q ? LW'(1) : len_q;
  assign tgt_wdata = single_q ? PW'(wbuf[beat_q*DW +: DW]) : wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      gnt_q    <= '0;
      tgt_q    <= '0;
      single_q <= 1'b0;
      write_q  <= 1'b0;
      err_q    <= 1'b0;
      len_q    <= '0;
      beat_q   <= '0;
      laddr_q  <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      err_seen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            gnt_q    <= arb_idx;
            write_q  <= sel_write;
            len_q    <= sel_len;
            wbuf     <= sel_wdata;
            laddr_q  <= dec_local;
            tgt_q    <= dec_sel;
            single_q <= TGT_SINGLE[dec_sel];
            beat_q   <= '0;
            rbuf     <= '0;
            if (req_ok) begin
              state <= ST_FWD;
              cnt   <= CNTW'(FWD_LAT - 1);
              err_q <= 1'b0;
            end else begin
              state    <= ST_RESP;
              err_q    <= 1'b1;
              err_seen <= 1'b1;
            end
          end
        end
        ST_FWD: begin
          if (cnt == '0) begin
            if (!single_q && write_q) begin
              state <= ST_COUNT;
              cnt   <= CNTW'(len_q) - CNTW'(1);
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (ack_sel) begin
            if (single_q) begin
              rbuf[beat_q*DW +: DW] <= sel_rdata[DW-1:0];
              if (last_beat) begin
                state <= ST_RESP;
              end else begin
                beat_q <= beat_q + LW'(1);
                state  <= ST_ISSUE;
              end
            end else begin
              rbuf  <= sel_rdata;
              state <= ST_COUNT;
              cnt   <= CNTW'(RET_LAT) + CNTW'(len_q) - CNTW'(1);
            end
          end
        end
        ST_COUNT: begin
          if (cnt == '0) state <= ST_RESP;
          else           cnt   <= cnt - CNTW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmf_checker.sv
module mmf_checker #(
  parameter int N_INIT = 2,
  parameter int N_TGT  = 2,
  parameter int LW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_INIT-1:0] ini_valid,
  input logic [N_INIT-1:0] ini_ready,
  input logic [N_TGT-1:0]  tgt_valid,
  input logic [LW-1:0]     tgt_len,
  input logic [N_INIT-1:0] rsp_valid,
  input logic              rsp_err,
  input logic              err_seen,
  input logic              accept,
  input logic              req_ok,
  input logic              single_q
);
  // R1: never two targets at once
  p_tgt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_valid));

  // R3: rejected request answered next cycle, no target touched
  p_err_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_ok) |=> (rsp_err && (|rsp_valid) && (tgt_valid == '0)));

  // R3: error flag is sticky
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> err_seen);

  // R5: a good request never completes in the cycle after acceptance
  p_ok_not_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ok) |=> (rsp_valid == '0));

  // R7: split beats are always one word
  p_single_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tgt_valid) && single_q) |-> (tgt_len == LW'(1)));

  // R8: ready goes only to the lowest requesting initiator
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ini_ready) |-> ($onehot(ini_ready) && ((ini_ready & ini_valid) != '0)
                      && ((ini_valid & (ini_ready - N_INIT'(1))) == '0)));

  // R8: no new grant while a response is out
  p_no_ready_in_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> (ini_ready == '0));

  // R9: single initiator per response, error only with a response
  p_rsp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
  p_err_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (|rsp_valid));
endmodule

bind mmap_fabric mmf_checker #(
  .N_INIT (N_INIT),
  .N_TGT  (N_TGT),
  .LW     (LW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ini_valid (ini_valid),
  .ini_ready (ini_ready),
  .tgt_valid (tgt_valid),
  .tgt_len   (tgt_len),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .err_seen  (err_seen),
  .accept    (accept),
  .req_ok    (req_ok),
  .single_q  (single_q)
);

// File: tb/mmap_fabric_tb.sv
module mmap_fabric_tb;
  localparam int F  = 2;
  localparam int R  = 2;
  localparam int D0 = 3;
  localparam int D1 = 2;
  localparam logic [15:0] B0 = 16'h0000;
  localparam logic [15:0] B1 = 16'h2000;
  localparam logic [1:0]  T_ERR = 2'd3;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [2:0]  len;
    logic [1:0]  tgt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0100, 3'd4, 2'd0},
    '{1'b0, 16'h0100, 3'd4, 2'd0},
    '{1'b1, 16'h2008, 3'd3, 2'd1},
    '{1'b0, 16'h2010, 3'd2, 2'd1},
    '{1'b1, 16'h0FFC, 3'd1, 2'd0},
    '{1'b0, 16'h1000, 3'd1, T_ERR},
    '{1'b1, 16'h203C, 3'd1, 2'd1},
    '{1'b0, 16'h2040, 3'd2, T_ERR},
    '{1'b0, 16'h0000, 3'd1, 2'd0},
    '{1'b1, 16'h0010, 3'd0, T_ERR},
    '{1'b0, 16'h2000, 3'd5, T_ERR},
    '{1'b0, 16'h1FFC, 3'd1, T_ERR}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   ini_valid = '0;
  logic [1:0]   ini_ready;
  logic [1:0]   ini_write = '0;
  logic [31:0]  ini_addr = '0;
  logic [5:0]   ini_len = '0;
  logic [255:0] ini_wdata = '0;
  logic [1:0]   rsp_valid;
  logic         rsp_err;
  logic [127:0] rsp_rdata;
  logic         err_seen;
  logic [1:0]   tgt_valid;
  logic         tgt_write;
  logic [15:0]  tgt_addr;
  logic [2:0]   tgt_len;
  logic [127:0] tgt_wdata;
  logic [1:0]   tgt_ack = '0;
  logic [255:0] tgt_rdata = '0;

  mmap_fabric u_dut (
    .clk (clk), .rst_n (rst_n),
    .ini_valid (ini_valid), .ini_ready (ini_ready), .ini_write (ini_write),
    .ini_addr (ini_addr), .ini_len (ini_len), .ini_wdata (ini_wdata),
    .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
    .err_seen (err_seen),
    .tgt_valid (tgt_valid), .tgt_write (tgt_write), .tgt_addr (tgt_addr),
    .tgt_len (tgt_len), .tgt_wdata (tgt_wdata),
    .tgt_ack (tgt_ack), .tgt_rdata (tgt_rdata)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input int k, input logic [15:0] a, input int j);
    return {8'hD0 + 8'(k), 8'h00, a + 16'(j)};
  endfunction

  function automatic logic [31:0] wr_word(input int v, input int j);
    return 32'h5A000000 | (32'(v) << 8) | 32'(j);
  endfunction

  function automatic int exp_lat(input logic [1:0] t, input logic wr, input int n);
    if (t == T_ERR) return 1;
    if (t == 2'd0) return wr ? (F + n + 1) : (F + D0 + R + n + 1);
    return F + n * (D1 + 1);
  endfunction

  // target models and issue log
  int          n_iss [2];
  logic [15:0] lg_addr [2][8];
  logic [2:0]  lg_len [2][8];
  logic [127:0] lg_wd [2][8];
  logic        lg_wr [2][8];
  int          pend [2];
  logic [15:0] iss_addr [2];

  task automatic clear_log();
    for (int k = 0; k < 2; k++) n_iss[k] = 0;
  endtask

  initial begin
    pend[0] = 0; pend[1] = 0;
    clear_log();
    forever begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        tgt_ack[k] = 1'b0;
        if (pend[k] > 0) begin
          pend[k]--;
          if (pend[k] == 0) begin
            tgt_ack[k] = 1'b1;
            for (int j = 0; j < 4; j++)
              tgt_rdata[k*128 + j*32 +: 32] = rd_word(k, iss_addr[k], j);
          end
        end
        if (tgt_valid[k]) begin
          if (n_iss[k] < 8) begin
            lg_addr[k][n_iss[k]] = tgt_addr;
            lg_len[k][n_iss[k]]  = tgt_len;
            lg_wd[k][n_iss[k]]   = tgt_wdata;
            lg_wr[k][n_iss[k]]   = tgt_write;
          end
          n_iss[k]++;
          iss_addr[k] = tgt_addr;
          pend[k] = (k == 0) ? D0 : D1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_req(input int ini, input logic wr, input logic [15:0] addr,
                        input logic [2:0] len, input int v, output int lat,
                        output logic err, output logic [127:0] rd,
                        output logic [1:0] rv);
    int acc;
    @(negedge clk);
    ini_valid[ini] = 1'b1;
    ini_write[ini] = wr;
    ini_addr[ini*16 +: 16] = addr;
    ini_len[ini*3 +: 3] = len;
    for (int j = 0; j < 4; j++) ini_wdata[ini*128 + j*32 +: 32] = wr_word(v, j);
    #1;
    while (!ini_ready[ini]) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    @(negedge clk);
    ini_valid[ini] = 1'b0;
    while (rsp_valid == 2'b00) @(negedge clk);
    lat = cyc - acc;
    err = rsp_err;
    rd  = rsp_rdata;
    rv  = rsp_valid;
  endtask

  initial begin
    int lat;
    logic err;
    logic [127:0] rd;
    logic [1:0] rv;
    logic any_err;
    logic [15:0] loc;
    any_err = 1'b0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(tgt_valid == 2'b00, "R10 tgt_valid after reset", 128'(tgt_valid), 0);
    chk(rsp_valid == 2'b00, "R10 rsp_valid after reset", 128'(rsp_valid), 0);
    chk(err_seen == 1'b0,   "R10 err_seen after reset", 128'(err_seen), 0);
    chk(ini_ready == 2'b00, "R10 ready with no request", 128'(ini_ready), 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      clear_log();
      do_req(0, t.wr, t.addr, t.len, v, lat, err, rd, rv);
      @(negedge clk);
      chk(rv == 2'b01, "R9 response to initiator 0 only", 128'(rv), 1);
      chk(err == (t.tgt == T_ERR), "R3/R4 error flag", 128'(err), 128'(t.tgt == T_ERR));
      chk(lat == exp_lat(t.tgt, t.wr, int'(t.len)), "R5/R6/R7/R3 latency",
          128'(lat), 128'(exp_lat(t.tgt, t.wr, int'(t.len))));
      if (t.tgt == T_ERR) begin
        any_err = 1'b1;
        chk(n_iss[0] == 0 && n_iss[1] == 0, "R3 R4 no target issued",
            128'(n_iss[0] + n_iss[1]), 0);
      end else if (t.tgt == 2'd0) begin
        loc = t.addr - B0;
        chk(n_iss[1] == 0, "R1 other target untouched", 128'(n_iss[1]), 0);
        chk(n_iss[0] == 1, "R5 burst issued once", 128'(n_iss[0]), 1);
        chk(lg_addr[0][0] == loc, "R2 local address", 128'(lg_addr[0][0]), 128'(loc));
        chk(lg_len[0][0] == t.len, "R5 burst length", 128'(lg_len[0][0]), 128'(t.len));
        if (t.wr) begin
          for (int j = 0; j < int'(t.len); j++)
            chk(lg_wd[0][0][j*32 +: 32] == wr_word(v, j), "R5 burst write word",
                128'(lg_wd[0][0][j*32 +: 32]), 128'(wr_word(v, j)));
        end else begin
          for (int j = 0; j < int'(t.len); j++)
            chk(rd[j*32 +: 32] == rd_word(0, loc, j), "R6 burst read word",
                128'(rd[j*32 +: 32]), 128'(rd_word(0, loc, j)));
        end
      end else begin
        loc = t.addr - B1;
        chk(n_iss[0] == 0, "R1 other target untouched", 128'(n_iss[0]), 0);
        chk(n_iss[1] == int'(t.len), "R7 one issue per word", 128'(n_iss[1]), 128'(t.len));
        for (int b = 0; b < int'(t.len); b++) begin
          chk(lg_addr[1][b] == loc + 16'(4 * b), "R7 R2 beat address",
              128'(lg_addr[1][b]), 128'(loc + 16'(4 * b)));
          chk(lg_len[1][b] == 3'd1, "R7 beat length", 128'(lg_len[1][b]), 1);
          if (t.wr)
            chk(lg_wd[1][b][31:0] == wr_word(v, b), "R7 beat write lane 0",
                128'(lg_wd[1][b][31:0]), 128'(wr_word(v, b)));
          else
            chk(rd[b*32 +: 32] == rd_word(1, loc + 16'(4 * b), 0), "R7 read word gathered",
                128'(rd[b*32 +: 32]), 128'(rd_word(1, loc + 16'(4 * b), 0)));
        end
      end
      chk(err_seen == any_err, "R3 sticky error flag", 128'(err_seen), 128'(any_err));
    end

    // R8: simultaneous requests, lowest index wins and holds the grant
    @(negedge clk);
    clear_log();
    ini_valid = 2'b11;
    ini_write = 2'b01;
    ini_addr  = {16'h2000, 16'h0200};
    ini_len   = {3'd1, 3'd2};
    #1;
    chk(ini_ready == 2'b01, "R8 lowest initiator granted", 128'(ini_ready), 1);
    @(negedge clk);
    ini_valid[0] = 1'b0;
    begin
      int busy_bad;
      busy_bad = 0;
      while (rsp_valid == 2'b00) begin
        if (ini_ready != 2'b00) busy_bad++;
        @(negedge clk);
      end
      chk(busy_bad == 0, "R8 no ready while busy", 128'(busy_bad), 0);
    end
    chk(rsp_valid == 2'b01, "R9 pulse only to winner", 128'(rsp_valid), 1);
    @(negedge clk);
    chk(rsp_valid == 2'b00, "R9 response lasts one cycle", 128'(rsp_valid), 0);
    chk(ini_ready == 2'b10, "R8 waiting initiator granted next", 128'(ini_ready), 2);
    @(negedge clk);
    ini_valid[1] = 1'b0;
    while (rsp_valid == 2'b00) @(negedge clk);
    chk(rsp_valid == 2'b10, "R9 pulse to second initiator", 128'(rsp_valid), 2);
    chk(rsp_rdata[31:0] == rd_word(1, 16'h0000, 0), "R7 second initiator read",
        128'(rsp_rdata[31:0]), 128'(rd_word(1, 16'h0000, 0)));
    chk(n_iss[0] == 1 && n_iss[1] == 1, "R1 each target issued once",
        128'(n_iss[0] * 16 + n_iss[1]), 128'h11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule